// File: doc/BRIEF.md
# Nanosecond-Based System Counter with Compare Timer

This block turns a stream of one-nanosecond strobes into a system-counter tick whose rate is set by a configured frequency in hertz. After reset, or after a configuration load, a small sequential divider works out the tick period as one second in nanoseconds divided by the frequency, truncated, with a floor of 1 ns. The counter does not move until that divide has finished. A prescaler then counts strobes up to the period and advances a 64-bit count once per period.

One compare timer watches the count. While it is enabled it reports a status bit once the count reaches the programmed compare value, and it raises an interrupt unless that interrupt is masked. The block also reports the time in nanoseconds at which the compare value falls due. It computes this from the same truncated period, so converting ticks to time and time to ticks give exact inverses. A small register port holds a software-visible frequency word, the compare value and the control bits, and lets the count be read back. The default configuration of 62.5 MHz gives a 16 ns period.

Top module: `gtt_tick_gen`

## Requirements
- R1: For a configured frequency f with 0 < f < 1,000,000,000, `tick_period_ns` equals 1,000,000,000 / f, truncated (62,500,000 gives 16, and 333,333,334 gives 2).
- R2: For f of 1,000,000,000 or more, `tick_period_ns` is 1, so the count advances on every strobe.
- R3: Once `ready` is high, `count` equals the number of `ns_strobe` cycles seen since `ready` rose, divided by the period and truncated.
- R4: After reset or a configuration load, `ready` stays low and `count` stays at 0 until the period divide completes, whatever `ns_strobe` does.
- R5: A configured frequency of 0 sets `cfg_err` high, keeps `ready` low and leaves `count` at 0.
- R6: The frequency word (register address 0) takes `cfg_freq_hz` at reset and at each configuration load. A write to it is stored and read back, and it changes neither the period nor the count rate.
- R7: The compare value is at address 1. The control word is at address 2, with bit 0 as the enable and bit 1 as the interrupt mask. Address 3 reads the count. One cycle after its inputs change, `timer_status` is high when the timer is enabled and count >= compare. `timer_irq` equals `timer_status` while the mask bit is clear.
- R8: While the enable bit is clear, `timer_status` and `timer_irq` are both low, whatever the mask and compare settings.
- R9: While `ready` is high, `next_expiry_ns` equals compare × period, registered one cycle after the compare value changes. It saturates at 2^63−1 when that product exceeds the signed 64-bit range.
- R10: A pulse on `cfg_load` clears the count and the prescaler, captures `cfg_freq_hz` and reruns the divide with the new frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_freq_hz | input | 64 | Configured tick frequency in Hz |
| cfg_load | input | 1 | Pulse: capture frequency, restart divide and count |
| ns_strobe | input | 1 | One pulse per elapsed nanosecond |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 freq, 1 compare, 2 control, 3 count) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| count | output | 64 | System counter value |
| tick_period_ns | output | 30 | Derived tick period in ns |
| ready | output | 1 | Divide complete, counting allowed |
| cfg_err | output | 1 | Configured frequency is zero |
| timer_status | output | 1 | Compare timer condition met |
| timer_irq | output | 1 | Unmasked timer interrupt |
| next_expiry_ns | output | 64 | Compare time in ns, saturated |

## Verification
If the divider is wrong, the period visible on `tick_period_ns` is wrong as soon as `ready` rises, and the count then drifts from strobes/period within one period of strobes. If the prescaler is wrong, the count is off by one after the first wrap or at a truncation boundary. A wrong compare path shows up in `timer_status` or `timer_irq` one cycle after the enable, mask or compare value changes. A faulty expiry product appears in `next_expiry_ns` one cycle after the compare write, and it is most visible at the edge of saturation.

// File: rtl/gtt_pkg.sv
// Package: shared constants and types for the tick generator.
// Assumes one second expressed in nanoseconds fits the period width.
package gtt_pkg;
    localparam int unsigned NS_PER_SEC = 1_000_000_000;

    typedef enum logic [1:0] {
        DIV_START = 2'd0,
        DIV_RUN   = 2'd1,
        DIV_DONE  = 2'd2,
        DIV_ERR   = 2'd3
    } div_state_e;

    typedef enum logic [1:0] {
        RA_FREQ  = 2'd0,
        RA_CMP   = 2'd1,
        RA_CTRL  = 2'd2,
        RA_COUNT = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/gtt_period_div.sv
// Module: sequential restoring divider producing the tick period.
// It divides one second in ns by the captured frequency, one quotient bit
// per cycle. Frequencies at or above 1 GHz give a period of 1. A zero
// frequency parks the divider in an error state. A load or reset restarts it.
module gtt_period_div
    import gtt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PER_W  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] freq_hz,
    output logic [PER_W-1:0]  period,
    output logic              ready,
    output logic              err
);
    localparam int BIT_W = $clog2(PER_W);
    localparam logic [PER_W-1:0]  DIVIDEND = PER_W'(NS_PER_SEC);
    localparam logic [DATA_W-1:0] GHZ      = DATA_W'(NS_PER_SEC);

    div_state_e         state_q;
    logic [PER_W-1:0]   fdiv_q;
    logic [PER_W-1:0]   rem_q;
    logic [PER_W-1:0]   quo_q;
    logic [BIT_W-1:0]   bit_q;
    logic [PER_W-1:0]   period_q;

    logic [PER_W:0]     trial;
    logic [PER_W:0]     fdiv_ext;
    logic               ge;
    logic [PER_W-1:0]   rem_next;
    logic [PER_W-1:0]   quo_next;

    // One trial subtraction step of the restoring division.
    always_comb begin
        trial    = {rem_q, DIVIDEND[bit_q]};
        fdiv_ext = {1'b0, fdiv_q};
        ge       = (trial >= fdiv_ext);
        rem_next = PER_W'(ge ? (trial - fdiv_ext) : trial);
        quo_next = quo_q;
        quo_next[bit_q] = ge;
    end

    // Divider sequencing: capture, iterate, finish or flag an error.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            state_q  <= DIV_START;
            fdiv_q   <= '0;
            rem_q    <= '0;
            quo_q    <= '0;
            bit_q    <= '0;
            period_q <= PER_W'(1);
        end else begin
            case (state_q)
                DIV_START: begin
                    if (freq_hz == '0) begin
                        state_q <= DIV_ERR;
                    end else if (freq_hz >= GHZ) begin
                        period_q <= PER_W'(1);
                        state_q  <= DIV_DONE;
                    end else begin
                        fdiv_q  <= freq_hz[PER_W-1:0];
                        rem_q   <= '0;
                        quo_q   <= '0;
                        bit_q   <= BIT_W'(PER_W-1);
                        state_q <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    rem_q <= rem_next;
                    quo_q <= quo_next;
                    if (bit_q == '0) begin
                        period_q <= quo_next;
                        state_q  <= DIV_DONE;
                    end else begin
                        bit_q <= bit_q - BIT_W'(1);
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    assign period = period_q;
    assign ready  = (state_q == DIV_DONE);
    assign err    = (state_q == DIV_ERR);

    AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (period != '0)); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !load) |=> err); // R5
endmodule

// File: rtl/gtt_tick_counter.sv
// Module: nanosecond prescaler and system counter.
// Counts strobes up to period-1 and then advances the count by one.
// It is frozen while the period is not ready and cleared by a load.
module gtt_tick_counter #(
    parameter int CNT_W = 64,
    parameter int PER_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             ready,
    input  logic             ns_strobe,
    input  logic [PER_W-1:0] period,
    output logic [CNT_W-1:0] count
);
    logic [PER_W-1:0] pre_q;
    logic [CNT_W-1:0] count_q;
    logic             wrap;

    // Prescaler terminal condition.
    assign wrap = (pre_q == (period - PER_W'(1)));

    // Prescaler and counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_q   <= '0;
            count_q <= '0;
        end else if (ready && ns_strobe) begin
            if (wrap) begin
                pre_q   <= '0;
                count_q <= count_q + CNT_W'(1);
            end else begin
                pre_q <= pre_q + PER_W'(1);
            end
        end
    end

    assign count = count_q;

    AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (pre_q < period)); // R3
    AST_NO_COUNT_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(count_q) || (count_q == '0))); // R4
endmodule

// File: rtl/gtt_compare.sv
// Module: compare timer status, interrupt and expiry time.
// Status is registered from enable and count >= compare. The interrupt is
// the status gated by the mask. Expiry is compare*period, saturated to the
// largest positive signed value of CNT_W bits.
module gtt_compare #(
    parameter int CNT_W = 64,
    parameter int PER_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready,
    input  logic             enable,
    input  logic             mask,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic [PER_W-1:0] period,
    output logic             status,
    output logic             irq,
    output logic [CNT_W-1:0] expiry_ns
);
    localparam int PROD_W = CNT_W + PER_W;
    localparam logic [CNT_W-1:0] SAT_MAX = {1'b0, {(CNT_W-1){1'b1}}};

    logic              status_q;
    logic [CNT_W-1:0]  expiry_q;
    logic [PROD_W-1:0] prod;
    logic              ovf;

    // Expiry product and signed-range overflow detection.
    always_comb begin
        prod = {{PER_W{1'b0}}, cmp} * {{CNT_W{1'b0}}, period};
        ovf  = |prod[PROD_W-1:CNT_W-1];
    end

    // Registered status and saturated expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            expiry_q <= '0;
        end else begin
            status_q <= enable && (count >= cmp);
            expiry_q <= !ready ? '0 : (ovf ? SAT_MAX : prod[CNT_W-1:0]);
        end
    end

    assign status    = status_q;
    assign irq       = status_q && !mask;
    assign expiry_ns = expiry_q;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!status && !irq)); // R8
    AST_EXPIRY_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !expiry_ns[CNT_W-1]); // R9
endmodule

// File: rtl/gtt_tick_gen.sv
// Module: top of the tick generator.
// Holds the software-visible frequency word, compare value and control
// bits, and connects the divider, counter and compare timer. The frequency
// word is read-as-written only. The actual rate comes from cfg_freq_hz.
module gtt_tick_gen
    import gtt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PER_W  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cfg_freq_hz,
    input  logic              cfg_load,
    input  logic              ns_strobe,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] count,
    output logic [PER_W-1:0]  tick_period_ns,
    output logic              ready,
    output logic              cfg_err,
    output logic              timer_status,
    output logic              timer_irq,
    output logic [DATA_W-1:0] next_expiry_ns
);
    logic [DATA_W-1:0] freq_reg_q;
    logic [DATA_W-1:0] cmp_q;
    logic              en_q;
    logic              mask_q;
    logic [PER_W-1:0]  period;
    logic [DATA_W-1:0] count_w;

    // Register file writes and frequency word capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_reg_q <= cfg_freq_hz;
            cmp_q      <= '1;
            en_q       <= 1'b0;
            mask_q     <= 1'b0;
        end else begin
            if (cfg_load) begin
                freq_reg_q <= cfg_freq_hz;
            end else if (reg_wr && reg_addr == RA_FREQ) begin
                freq_reg_q <= reg_wdata;
            end
            if (reg_wr && reg_addr == RA_CMP) begin
                cmp_q <= reg_wdata;
            end
            if (reg_wr && reg_addr == RA_CTRL) begin
                en_q   <= reg_wdata[0];
                mask_q <= reg_wdata[1];
            end
        end
    end

    // Read data selection.
    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_FREQ:  reg_rdata = freq_reg_q;
            RA_CMP:   reg_rdata = cmp_q;
            RA_CTRL:  reg_rdata = {{(DATA_W-2){1'b0}}, mask_q, en_q};
            default:  reg_rdata = count_w;
        endcase
    end

    gtt_period_div #(.DATA_W(DATA_W), .PER_W(PER_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .freq_hz (cfg_freq_hz),
        .period  (period),
        .ready   (ready),
        .err     (cfg_err)
    );

    gtt_tick_counter #(.CNT_W(DATA_W), .PER_W(PER_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_load),
        .ready     (ready),
        .ns_strobe (ns_strobe),
        .period    (period),
        .count     (count_w)
    );

    gtt_compare #(.CNT_W(DATA_W), .PER_W(PER_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .enable    (en_q),
        .mask      (mask_q),
        .count     (count_w),
        .cmp       (cmp_q),
        .period    (period),
        .status    (timer_status),
        .irq       (timer_irq),
        .expiry_ns (next_expiry_ns)
    );

    assign count          = count_w;
    assign tick_period_ns = period;

    AST_FREQ_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_wr && reg_addr == RA_FREQ) && !cfg_load) |=> $stable(freq_reg_q)); // R6
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (count == '0 && !ready)); // R10
endmodule

// File: tb/gtt_tick_gen_tb.sv
`timescale 1ns/1ps
module gtt_tick_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cfg_freq_hz = 64'd62_500_000;
    logic        cfg_load = 1'b0;
    logic        ns_strobe = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata, count, next_expiry_ns;
    logic [29:0] tick_period_ns;
    logic        ready, cfg_err, timer_status, timer_irq;

    int errors = 0;
    int checks = 0;
    longint unsigned strobes = 0;

    gtt_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_freq_hz(cfg_freq_hz), .cfg_load(cfg_load),
        .ns_strobe(ns_strobe), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count),
        .tick_period_ns(tick_period_ns), .ready(ready), .cfg_err(cfg_err),
        .timer_status(timer_status), .timer_irq(timer_irq),
        .next_expiry_ns(next_expiry_ns)
    );

    always #5 clk = ~clk;

    function automatic longint unsigned exp_period(longint unsigned f);
        return (f >= 64'd1_000_000_000) ? 64'd1 : (64'd1_000_000_000 / f);
    endfunction

    function automatic logic [63:0] exp_expiry(logic [63:0] c, longint unsigned p);
        logic [127:0] prod;
        prod = {64'd0, c} * {64'd0, p};
        return (prod > 128'h7FFF_FFFF_FFFF_FFFF) ? 64'h7FFF_FFFF_FFFF_FFFF : prod[63:0];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(input int n);
        ns_strobe = 1'b1;
        idle(n);
        ns_strobe = 1'b0;
        idle(1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        idle(1);
        reg_wr = 1'b0;
        idle(2);
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!ready && n < 200) begin idle(1); n++; end
        chk("R4 ready reached", {63'd0, ready}, 64'd1);
        strobes = 0;
    endtask

    task automatic load(input logic [63:0] f);
        cfg_freq_hz = f;
        cfg_load = 1'b1;
        idle(1);
        cfg_load = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [63:0] d;
        void'($urandom(32'h5EED_0042));
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R4 not ready after reset", {63'd0, ready}, 64'd0);
        chk("R4 count zero after reset", count, 64'd0);
        strobe(10);
        chk("R4 no count during divide", count, 64'd0);
        chk("R4 still dividing", {63'd0, ready}, 64'd0);
        wait_ready();
        chk("R1 default period", {34'd0, tick_period_ns}, 64'd16);
        rd(2'd0, d);
        chk("R6 freq word reset value", d, 64'd62_500_000);
        idle(1);

        strobe(100); strobes += 100;
        chk("R3 count 100/16", count, strobes / 16);

        wr(2'd0, 64'd5);
        rd(2'd0, d);
        chk("R6 freq word readback", d, 64'd5);
        idle(1);
        strobe(60); strobes += 60;
        chk("R6 rate unchanged by write", count, strobes / 16);
        chk("R6 period unchanged", {34'd0, tick_period_ns}, 64'd16);
        rd(2'd3, d);
        chk("R7 count readable", d, 64'd10);
        idle(1);

        wr(2'd1, 64'd12);
        wr(2'd2, 64'd1);
        chk("R7 status below compare", {63'd0, timer_status}, 64'd0);
        strobe(32); strobes += 32;
        idle(1);
        chk("R7 status at compare", {63'd0, timer_status}, 64'd1);
        chk("R7 irq at compare", {63'd0, timer_irq}, 64'd1);
        wr(2'd2, 64'd3);
        chk("R7 masked irq", {63'd0, timer_irq}, 64'd0);
        chk("R7 status under mask", {63'd0, timer_status}, 64'd1);
        wr(2'd2, 64'd0);
        chk("R8 disabled status", {63'd0, timer_status}, 64'd0);
        chk("R8 disabled irq", {63'd0, timer_irq}, 64'd0);
        wr(2'd2, 64'd2);
        chk("R8 disabled masked status", {63'd0, timer_status}, 64'd0);

        wr(2'd1, 64'd1000);
        chk("R9 expiry plain", next_expiry_ns, exp_expiry(64'd1000, 16));
        wr(2'd1, 64'h4000_0000_0000_0000);
        chk("R9 expiry saturates", next_expiry_ns, 64'h7FFF_FFFF_FFFF_FFFF);
        wr(2'd1, 64'h07FF_FFFF_FFFF_FFFF);
        chk("R9 expiry at edge", next_expiry_ns, exp_expiry(64'h07FF_FFFF_FFFF_FFFF, 16));

        load(64'd2_000_000_000);
        chk("R10 count cleared by load", count, 64'd0);
        wait_ready();
        chk("R2 period above 1GHz", {34'd0, tick_period_ns}, 64'd1);
        rd(2'd0, d);
        chk("R6 freq word on load", d, 64'd2_000_000_000);
        idle(1);
        strobe(50);
        chk("R2 count per strobe", count, 64'd50);
        load(64'd1_000_000_000); wait_ready();
        chk("R2 period at 1GHz", {34'd0, tick_period_ns}, 64'd1);
        load(64'd999_999_999); wait_ready();
        chk("R1 period just below 1GHz", {34'd0, tick_period_ns}, 64'd1);
        load(64'd333_333_334); wait_ready();
        chk("R1 truncation", {34'd0, tick_period_ns}, 64'd2);
        strobe(7);
        chk("R3 count 7/2", count, 64'd3);

        for (int k = 0; k < 6; k++) begin
            longint unsigned f, p;
            int n;
            f = 64'd1_000_000 + longint'($urandom % 999_000_000);
            p = exp_period(f);
            load(f);
            wait_ready();
            chk("R10 R1 random period", {34'd0, tick_period_ns}, p);
            n = 1 + int'($urandom % 2000);
            strobe(n);
            chk("R3 random count", count, longint'(n) / p);
        end

        load(64'd0);
        idle(40);
        chk("R5 cfg_err set", {63'd0, cfg_err}, 64'd1);
        chk("R5 not ready", {63'd0, ready}, 64'd0);
        strobe(20);
        chk("R5 count stays zero", count, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule